// File: doc/BRIEF.md
# Repeated String Transfer Sequencer

This block carries out one string operation on a byte-wide, single-port memory. The operation is a move, load, store, compare or scan, and it runs over one element or a repeated run of elements. A start pulse hands it the source and destination pointers, the element count, the two segment bases, the accumulator, the zero flag, the direction flag and the element size. It then walks the elements in order. For each element it issues the memory reads and writes, steps the pointers, counts the count down and applies the stop rule of the selected repeat prefix. When it ends, it pulses `done` and holds the final pointers, count, accumulator and zero flag on its outputs.

A physical byte address is the segment base shifted left by four, plus the pointer offset. A word element takes two consecutive bytes, and the sequencer transfers them as two single-byte accesses. The internal machine has seven states. IDLE waits for a start pulse (IDLE→TEST). TEST checks the count and either terminates (TEST→FINISH) or enters the first access state: TEST→RD_SRC for move, load and compare, TEST→WR_DST for store, TEST→RD_DST for scan. RD_SRC reads the source element and then goes to WR_DST (move), RD_DST (compare) or STEP (load). RD_DST reads the destination element, and WR_DST writes it. Both go to STEP. STEP commits the pointers, the accumulator and the flag, then goes either back to TEST (STEP→TEST, repeat) or to FINISH (STEP→FINISH, stop). FINISH raises `done` for one cycle and goes back to IDLE (FINISH→IDLE).

Top module: `strseq_top`

## Requirements
- R1: The source element is read at src_seg·16 + src_ptr. The destination element is read or written at dst_seg·16 + dst_ptr. A word element takes two bytes: the low byte at offset+0 and the high byte at offset+1, with the offset addition wrapping at 16 bits.
- R2: After each element, each pointer the operation uses changes by 1 for a byte (`wide`=0) or 2 for a word (`wide`=1). It goes up when `dir_in`=0 and down when `dir_in`=1.
- R3: Operation codes are move=0, load=1, store=2, compare=3 and scan=4. A load copies the element at the source into the accumulator (byte: low 8 bits only, high 8 bits kept) and steps only the source pointer. A store writes the accumulator (the low byte, or both bytes) to the destination and steps only the destination pointer. A scan steps only the destination pointer. A move and a compare step both pointers.
- R4: Prefix codes are none=0, repeat=1, repeat-while-equal=2 and repeat-while-unequal=3. With any prefix, the count is tested before each element. A zero count ends the run with no memory access. A non-zero count is decremented and one element is processed.
- R5: With prefix 2 on a compare or scan, the run ends after an element whose result clears the zero flag.
- R6: With prefix 3 on a compare or scan, the run ends after an element whose result sets the zero flag.
- R7: A compare sets the zero flag when the source element equals the destination element. A scan sets it when the accumulator (low byte, or whole word) equals the destination element. Move, load and store leave the zero flag unchanged. With prefixes 2 and 3, move, load and store follow the count alone.
- R8: With prefix 0, exactly one element is processed and the count is left unchanged.
- R9: Each memory request holds its address, write enable and write data unchanged until it is acknowledged.
- R10: `busy` is high from the cycle after an accepted start until the end of the run. `done` is high for exactly one cycle at the end, and `busy` falls in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted only while idle) |
| op | input | 3 | Operation code |
| pfx | input | 2 | Repeat prefix code |
| wide | input | 1 | 1 = word element, 0 = byte element |
| dir_in | input | 1 | 0 = pointers increase, 1 = pointers decrease |
| src_ptr_in | input | 16 | Initial source pointer offset |
| dst_ptr_in | input | 16 | Initial destination pointer offset |
| count_in | input | 16 | Initial element count |
| src_seg_in | input | 16 | Source segment base |
| dst_seg_in | input | 16 | Destination segment base |
| acc_in | input | 16 | Initial accumulator |
| zf_in | input | 1 | Initial zero flag |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write access |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with acknowledge |
| mem_ack | input | 1 | Access complete |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| src_ptr_out | output | 16 | Current/final source pointer |
| dst_ptr_out | output | 16 | Current/final destination pointer |
| count_out | output | 16 | Current/final count |
| acc_out | output | 16 | Current/final accumulator |
| zf_out | output | 1 | Current/final zero flag |

## Verification
The assertions assume that `mem_ack` is raised only in response to an outstanding request and for one cycle per access. They also assume that `start` is pulsed only while `busy` is low. The bench memory keeps to this: it answers at a falling edge after a programmable wait of zero to two cycles, drops the acknowledge on the very next falling edge, and starts a new run only after `done`. Memory contents are drawn from values 0 and 1, so compares and scans see both matching and mismatching elements, including mismatches in the high byte alone. This exercises the early stops of both conditional prefixes across byte and word sizes and both directions.

// File: rtl/strseq_pkg.sv
package strseq_pkg;

    typedef enum logic [2:0] {
        OP_MOVE  = 3'd0,
        OP_LOAD  = 3'd1,
        OP_STORE = 3'd2,
        OP_CMP   = 3'd3,
        OP_SCAN  = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        PF_NONE     = 2'd0,
        PF_REPEAT   = 2'd1,
        PF_WHILE_EQ = 2'd2,
        PF_WHILE_NE = 2'd3
    } pfx_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_TEST,
        S_RD_SRC,
        S_RD_DST,
        S_WR_DST,
        S_STEP,
        S_FINISH
    } state_e;

    function automatic logic op_reads_src(op_e o);
        return (o == OP_MOVE) || (o == OP_LOAD) || (o == OP_CMP);
    endfunction

    function automatic logic op_touches_dst(op_e o);
        return (o == OP_MOVE) || (o == OP_STORE) || (o == OP_CMP) || (o == OP_SCAN);
    endfunction

    function automatic logic op_matches(op_e o);
        return (o == OP_CMP) || (o == OP_SCAN);
    endfunction

endpackage

// File: rtl/strseq_agu.sv
module strseq_agu #(
    parameter int OW = 16,
    parameter int SH = 4,
    localparam int AW = OW + SH
) (
    input  logic [OW-1:0] seg,
    input  logic [OW-1:0] off,
    input  logic          byte_sel,
    output logic [AW-1:0] addr
);
    logic [OW-1:0] off_b;

    always_comb begin
        off_b = off + {{(OW-1){1'b0}}, byte_sel};
        addr  = {seg, {SH{1'b0}}} + {{SH{1'b0}}, off_b};
    end
endmodule

// File: rtl/strseq_step.sv
module strseq_step #(
    parameter int OW = 16
) (
    input  logic [OW-1:0] ptr,
    input  logic          wide,
    input  logic          dir,
    output logic [OW-1:0] nxt
);
    logic [OW-1:0] amount;

    always_comb begin
        amount = wide ? OW'(2) : OW'(1);
        nxt    = dir ? (ptr - amount) : (ptr + amount);
    end
endmodule

// File: rtl/strseq_fsm.sv
module strseq_fsm
    import strseq_pkg::*;
#(
    parameter int OW = 16,
    parameter int DW = 8,
    localparam int EW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    op_in,
    input  logic [1:0]    pfx_in,
    input  logic          wide_in,
    input  logic          dir_in,
    input  logic [OW-1:0] src_ptr_in,
    input  logic [OW-1:0] dst_ptr_in,
    input  logic [OW-1:0] count_in,
    input  logic [OW-1:0] src_seg_in,
    input  logic [OW-1:0] dst_seg_in,
    input  logic [EW-1:0] acc_in,
    input  logic          zf_in,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    input  logic [OW-1:0] src_ptr_nxt,
    input  logic [OW-1:0] dst_ptr_nxt,
    output logic [OW-1:0] src_ptr_q,
    output logic [OW-1:0] dst_ptr_q,
    output logic [OW-1:0] count_q,
    output logic [OW-1:0] src_seg_q,
    output logic [OW-1:0] dst_seg_q,
    output logic [EW-1:0] acc_q,
    output logic          zf_q,
    output logic          wide_q,
    output logic          dir_q,
    output logic [1:0]    pfx_q,
    output logic          use_dst,
    output logic          byte_sel,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    output logic          busy,
    output logic          done
);
    state_e        state, state_nx;
    op_e           op_q;
    pfx_e          pf;
    logic          half;
    logic          last_byte;
    logic          hit;
    logic [EW-1:0] src_buf;
    logic [EW-1:0] dst_buf;
    logic [EW-1:0] cmp_a;
    logic [EW-1:0] wr_src;

    assign pf        = pfx_e'(pfx_q);
    assign last_byte = !wide_q || half;

    always_comb begin
        cmp_a = (op_q == OP_CMP) ? src_buf : acc_q;
        hit   = wide_q ? (cmp_a == dst_buf) : (cmp_a[DW-1:0] == dst_buf[DW-1:0]);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (start) state_nx = S_TEST;
            S_TEST: begin
                if (pf != PF_NONE && count_q == '0) state_nx = S_FINISH;
                else if (op_q == OP_STORE)          state_nx = S_WR_DST;
                else if (op_q == OP_SCAN)           state_nx = S_RD_DST;
                else                                state_nx = S_RD_SRC;
            end
            S_RD_SRC: if (mem_ack && last_byte) begin
                if (op_q == OP_MOVE)     state_nx = S_WR_DST;
                else if (op_q == OP_CMP) state_nx = S_RD_DST;
                else                     state_nx = S_STEP;
            end
            S_RD_DST: if (mem_ack && last_byte) state_nx = S_STEP;
            S_WR_DST: if (mem_ack && last_byte) state_nx = S_STEP;
            S_STEP: begin
                if (pf == PF_NONE)                                          state_nx = S_FINISH;
                else if (op_matches(op_q) && pf == PF_WHILE_EQ && !hit)     state_nx = S_FINISH;
                else if (op_matches(op_q) && pf == PF_WHILE_NE && hit)      state_nx = S_FINISH;
                else                                                        state_nx = S_TEST;
            end
            S_FINISH: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wr_src    = (op_q == OP_MOVE) ? src_buf : acc_q;
        mem_req   = (state == S_RD_SRC) || (state == S_RD_DST) || (state == S_WR_DST);
        mem_we    = (state == S_WR_DST);
        use_dst   = (state != S_RD_SRC);
        byte_sel  = half;
        mem_wdata = half ? wr_src[EW-1:DW] : wr_src[DW-1:0];
        busy      = (state != S_IDLE);
        done      = (state == S_FINISH);
    end

    // operand and register updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q      <= OP_MOVE;
            pfx_q     <= 2'd0;
            wide_q    <= 1'b0;
            dir_q     <= 1'b0;
            src_ptr_q <= '0;
            dst_ptr_q <= '0;
            count_q   <= '0;
            src_seg_q <= '0;
            dst_seg_q <= '0;
            acc_q     <= '0;
            zf_q      <= 1'b0;
            half      <= 1'b0;
            src_buf   <= '0;
            dst_buf   <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    op_q      <= op_e'(op_in);
                    pfx_q     <= pfx_in;
                    wide_q    <= wide_in;
                    dir_q     <= dir_in;
                    src_ptr_q <= src_ptr_in;
                    dst_ptr_q <= dst_ptr_in;
                    count_q   <= count_in;
                    src_seg_q <= src_seg_in;
                    dst_seg_q <= dst_seg_in;
                    acc_q     <= acc_in;
                    zf_q      <= zf_in;
                    half      <= 1'b0;
                end
                S_TEST: if (pf != PF_NONE && count_q != '0) count_q <= count_q - 1'b1;
                S_RD_SRC: if (mem_ack) begin
                    if (half) src_buf[EW-1:DW] <= mem_rdata;
                    else      src_buf[DW-1:0]  <= mem_rdata;
                    half <= !last_byte;
                end
                S_RD_DST: if (mem_ack) begin
                    if (half) dst_buf[EW-1:DW] <= mem_rdata;
                    else      dst_buf[DW-1:0]  <= mem_rdata;
                    half <= !last_byte;
                end
                S_WR_DST: if (mem_ack) half <= !last_byte;
                S_STEP: begin
                    if (op_reads_src(op_q))   src_ptr_q <= src_ptr_nxt;
                    if (op_touches_dst(op_q)) dst_ptr_q <= dst_ptr_nxt;
                    if (op_q == OP_LOAD) begin
                        if (wide_q) acc_q <= src_buf;
                        else        acc_q[DW-1:0] <= src_buf[DW-1:0];
                    end
                    if (op_matches(op_q)) zf_q <= hit;
                end
                S_FINISH: ;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/strseq_top.sv
module strseq_top #(
    parameter int OW = 16,
    parameter int SH = 4,
    parameter int DW = 8,
    localparam int AW = OW + SH,
    localparam int EW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    op,
    input  logic [1:0]    pfx,
    input  logic          wide,
    input  logic          dir_in,
    input  logic [OW-1:0] src_ptr_in,
    input  logic [OW-1:0] dst_ptr_in,
    input  logic [OW-1:0] count_in,
    input  logic [OW-1:0] src_seg_in,
    input  logic [OW-1:0] dst_seg_in,
    input  logic [EW-1:0] acc_in,
    input  logic          zf_in,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    output logic          busy,
    output logic          done,
    output logic [OW-1:0] src_ptr_out,
    output logic [OW-1:0] dst_ptr_out,
    output logic [OW-1:0] count_out,
    output logic [EW-1:0] acc_out,
    output logic          zf_out
);
    logic [1:0][OW-1:0] ptr_cur;
    logic [1:0][OW-1:0] ptr_nxt;
    logic [OW-1:0]      src_seg_q, dst_seg_q;
    logic               wide_q, dir_q, use_dst, byte_sel;
    logic [1:0]         pfx_q;

    strseq_fsm #(.OW(OW), .DW(DW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .op_in      (op),
        .pfx_in     (pfx),
        .wide_in    (wide),
        .dir_in     (dir_in),
        .src_ptr_in (src_ptr_in),
        .dst_ptr_in (dst_ptr_in),
        .count_in   (count_in),
        .src_seg_in (src_seg_in),
        .dst_seg_in (dst_seg_in),
        .acc_in     (acc_in),
        .zf_in      (zf_in),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .src_ptr_nxt(ptr_nxt[0]),
        .dst_ptr_nxt(ptr_nxt[1]),
        .src_ptr_q  (ptr_cur[0]),
        .dst_ptr_q  (ptr_cur[1]),
        .count_q    (count_out),
        .src_seg_q  (src_seg_q),
        .dst_seg_q  (dst_seg_q),
        .acc_q      (acc_out),
        .zf_q       (zf_out),
        .wide_q     (wide_q),
        .dir_q      (dir_q),
        .pfx_q      (pfx_q),
        .use_dst    (use_dst),
        .byte_sel   (byte_sel),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .busy       (busy),
        .done       (done)
    );

    for (genvar i = 0; i < 2; i++) begin : g_step
        strseq_step #(.OW(OW)) u_step (
            .ptr (ptr_cur[i]),
            .wide(wide_q),
            .dir (dir_q),
            .nxt (ptr_nxt[i])
        );
    end

    strseq_agu #(.OW(OW), .SH(SH)) u_agu (
        .seg     (use_dst ? dst_seg_q : src_seg_q),
        .off     (use_dst ? ptr_cur[1] : ptr_cur[0]),
        .byte_sel(byte_sel),
        .addr    (mem_addr)
    );

    assign src_ptr_out = ptr_cur[0];
    assign dst_ptr_out = ptr_cur[1];
endmodule

// File: rtl/strseq_chk.sv
module strseq_chk #(
    parameter int OW = 16,
    parameter int AW = 20,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [1:0]    pfx_in,
    input logic [OW-1:0] count_in,
    input logic          busy,
    input logic          done,
    input logic          mem_req,
    input logic          mem_ack,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic [OW-1:0] src_ptr_out,
    input logic [OW-1:0] count_out,
    input logic [1:0]    pfx_q
);
    logic          zero_run;
    logic          busy_prev;
    logic [OW-1:0] ptr_prev, cnt_prev;
    logic [OW-1:0] ptr_diff;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zero_run  <= 1'b0;
            busy_prev <= 1'b0;
            ptr_prev  <= '0;
            cnt_prev  <= '0;
        end else begin
            busy_prev <= busy;
            ptr_prev  <= src_ptr_out;
            cnt_prev  <= count_out;
            if (start && !busy && pfx_in != 2'd0 && count_in == '0) zero_run <= 1'b1;
            else if (done)                                           zero_run <= 1'b0;
        end
    end

    assign ptr_diff = src_ptr_out - ptr_prev;

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    // R4
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_run |-> !mem_req);

    // R4
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && busy_prev |-> count_out <= cnt_prev);

    // R2
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && busy_prev && src_ptr_out != ptr_prev |->
            ptr_diff == OW'(1) || ptr_diff == OW'(2) || ptr_diff == {OW{1'b1}} || ptr_diff == {{(OW-1){1'b1}}, 1'b0});

    // R8
    single_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && busy_prev && pfx_q == 2'd0 |-> count_out == cnt_prev);
endmodule

bind strseq_top strseq_chk #(.OW(OW), .AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .pfx_in     (pfx),
    .count_in   (count_in),
    .busy       (busy),
    .done       (done),
    .mem_req    (mem_req),
    .mem_ack    (mem_ack),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .src_ptr_out(src_ptr_out),
    .count_out  (count_out),
    .pfx_q      (pfx_q)
);

// File: tb/strseq_top_bench.sv
`timescale 1ns/1ps
module strseq_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  pfx = '0;
    logic        wide = 1'b0;
    logic        dir_in = 1'b0;
    logic [15:0] src_ptr_in = '0, dst_ptr_in = '0, count_in = '0;
    logic [15:0] src_seg_in = '0, dst_seg_in = '0, acc_in = '0;
    logic        zf_in = 1'b0;
    logic        mem_req, mem_we, busy, done, zf_out;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic [15:0] src_ptr_out, dst_ptr_out, count_out, acc_out;

    int tests = 0;
    int fails = 0;
    int lat = 0;
    int wait_cnt = 0;
    int access_cnt = 0;

    logic [7:0]  dmem [1024];
    logic [7:0]  rmem [1024];
    logic [15:0] e_src, e_dst, e_cnt, e_acc;
    logic        e_zf;

    always #2 clk = ~clk;

    strseq_top u_strseq_top (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .pfx(pfx), .wide(wide),
        .dir_in(dir_in), .src_ptr_in(src_ptr_in), .dst_ptr_in(dst_ptr_in),
        .count_in(count_in), .src_seg_in(src_seg_in), .dst_seg_in(dst_seg_in),
        .acc_in(acc_in), .zf_in(zf_in), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .busy(busy), .done(done), .src_ptr_out(src_ptr_out),
        .dst_ptr_out(dst_ptr_out), .count_out(count_out), .acc_out(acc_out),
        .zf_out(zf_out)
    );

    // memory model: answers at falling edges after lat waiting cycles
    always @(negedge clk) begin
        if (mem_ack) mem_ack = 1'b0;
        else if (mem_req) begin
            if (wait_cnt >= lat) begin
                if (mem_we) dmem[mem_addr[9:0]] = mem_wdata;
                else        mem_rdata = dmem[mem_addr[9:0]];
                mem_ack = 1'b1;
                wait_cnt = 0;
                access_cnt++;
            end else wait_cnt++;
        end
    end

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: %s got %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic int phys(input logic [15:0] seg, input logic [15:0] off, input int k);
        logic [15:0] o;
        logic [19:0] a;
        o = off + 16'(k);
        a = {seg, 4'h0} + {4'h0, o};
        return int'(a[9:0]);
    endfunction

    function automatic logic [15:0] rd_el(input logic [15:0] seg, input logic [15:0] off, input bit w);
        logic [15:0] v;
        v = {8'h00, rmem[phys(seg, off, 0)]};
        if (w) v[15:8] = rmem[phys(seg, off, 1)];
        return v;
    endfunction

    // reference model written from the requirements
    task automatic ref_run(input int o, input int p, input bit w, input bit d,
                           input logic [15:0] sseg, input logic [15:0] dseg);
        logic [15:0] st, a, b;
        st = w ? 16'd2 : 16'd1;
        for (int guard = 0; guard < 100; guard++) begin
            if (p != 0 && e_cnt == 0) break;                        // R4
            if (p != 0) e_cnt = e_cnt - 1;
            case (o)
                0: begin
                    for (int k = 0; k < (w ? 2 : 1); k++)
                        rmem[phys(dseg, e_dst, k)] = rmem[phys(sseg, e_src, k)];
                    e_src = d ? e_src - st : e_src + st;
                    e_dst = d ? e_dst - st : e_dst + st;
                end
                1: begin
                    a = rd_el(sseg, e_src, w);
                    if (w) e_acc = a; else e_acc[7:0] = a[7:0];
                    e_src = d ? e_src - st : e_src + st;
                end
                2: begin
                    rmem[phys(dseg, e_dst, 0)] = e_acc[7:0];
                    if (w) rmem[phys(dseg, e_dst, 1)] = e_acc[15:8];
                    e_dst = d ? e_dst - st : e_dst + st;
                end
                3: begin
                    a = rd_el(sseg, e_src, w);
                    b = rd_el(dseg, e_dst, w);
                    e_zf = w ? (a == b) : (a[7:0] == b[7:0]);
                    e_src = d ? e_src - st : e_src + st;
                    e_dst = d ? e_dst - st : e_dst + st;
                end
                default: begin
                    b = rd_el(dseg, e_dst, w);
                    e_zf = w ? (e_acc == b) : (e_acc[7:0] == b[7:0]);
                    e_dst = d ? e_dst - st : e_dst + st;
                end
            endcase
            if (p == 0) break;
            if (o >= 3 && p == 2 && !e_zf) break;                  // R5
            if (o >= 3 && p == 3 && e_zf) break;                   // R6
        end
    endtask

    task automatic run_one(input int o, input int p, input bit w, input bit d,
                           input logic [15:0] cnt, input int seed);
        int mism;
        int n;
        string cnt_tag;
        for (int a = 0; a < 1024; a++) begin
            dmem[a] = 8'((((a * 3) >> 1) ^ (a >> 3) ^ seed) & 1);
            rmem[a] = dmem[a];
        end
        lat = seed % 3;
        access_cnt = 0;
        op = 3'(o); pfx = 2'(p); wide = w; dir_in = d;
        src_ptr_in = 16'h0040; dst_ptr_in = 16'h0048; count_in = cnt;
        src_seg_in = 16'h0010; dst_seg_in = 16'h0020;
        acc_in = {7'h00, 1'(seed >> 1), 7'h00, 1'(seed)};
        zf_in = 1'(seed >> 2);
        e_src = src_ptr_in; e_dst = dst_ptr_in; e_cnt = cnt; e_acc = acc_in; e_zf = zf_in;
        ref_run(o, p, w, d, src_seg_in, dst_seg_in);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10", "busy after start", {31'd0, busy}, 32'd1);
        n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check("R10", "done reached", {31'd0, done}, 32'd1);
        check("R2", "source pointer", {16'd0, src_ptr_out}, {16'd0, e_src});
        check("R2", "destination pointer", {16'd0, dst_ptr_out}, {16'd0, e_dst});
        cnt_tag = (p == 0) ? "R8" : "R4";
        check(cnt_tag, "count", {16'd0, count_out}, {16'd0, e_cnt});
        check("R3", "accumulator", {16'd0, acc_out}, {16'd0, e_acc});
        check((o >= 3) ? "R5/R6" : "R7", "zero flag", {31'd0, zf_out}, {31'd0, e_zf});
        @(negedge clk);
        check("R10", "done one cycle", {30'd0, done, busy}, 32'd0);
        mism = 0;
        for (int a = 0; a < 1024; a++) if (dmem[a] !== rmem[a]) mism++;
        check("R1", "memory mismatches", 32'(mism), 32'd0);
        if (p != 0 && cnt == 0)
            check("R4", "accesses with zero count", 32'(access_cnt), 32'd0);
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int seed;
        logic [15:0] cnts [4];
        cnts[0] = 16'd0; cnts[1] = 16'd1; cnts[2] = 16'd2; cnts[3] = 16'd5;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", "reset busy/done/req", {29'd0, busy, done, mem_req}, 32'd0);
        seed = 0;
        for (int o = 0; o < 5; o++)
            for (int p = 0; p < 4; p++)
                for (int w = 0; w < 2; w++)
                    for (int d = 0; d < 2; d++)
                        for (int c = 0; c < 4; c++) begin
                            run_one(o, p, 1'(w), 1'(d), cnts[c], seed);
                            seed++;
                        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule